// File: doc/BRIEF.md
# Multi-Channel Reloading Timer Unit

This block groups two or three independent down-counting timer channels behind one byte-addressed register window. Each channel has a reload value, a live count and a control word. The control word picks a clock prescale, enables the channel's interrupt and holds the channel's underflow flag. When a running channel counts past zero, it takes its reload value again and raises its flag. The flag, gated by the enable, drives that channel's own interrupt line.

A shared start register holds one run bit per channel. Software starts, pauses and resumes channels through it without losing the count or the prescaler phase. An optional one-bit output-control register sits at offset 0 and drives a pin directly. A parameter decides whether the third channel exists. Accesses use a simple valid/write strobe. Read data returns one cycle later, and an access that hits nothing produces a one-cycle error pulse.

Top module: `tmr_unit`

## Requirements
- R1: After reset every channel's reload and count registers read 0xFFFFFFFF. Everything else reads 0: the start register, the output-control register and each control word. All interrupt outputs, `octl_o` and `err_pulse` are low.
- R2: Decoded word offsets: 0x00 output control, 0x04 start. Channel c's bank lies at 0x08 + 12*c and holds reload (+0), count (+4) and control (+8). Any other or misaligned byte address reads as 0, changes no register, and sets `err_pulse` for one cycle, in the cycle after the access.
- R3: The output-control register keeps only write-data bit 0 and drives `octl_o`. It reads back zero-extended.
- R4: Bit c of the start register runs channel c. A read returns the bits last written for the channels that exist, and the bits above them read 0.
- R5: In the control word, bits [2:0] select the prescale (sel). A running channel's count changes once every 4^(sel+1) running cycles, and sel values above 4 behave as 4.
- R6: A prescaled step from count 0 loads the reload value and sets the underflow flag (control bit 4). Any other step decrements the count by one.
- R7: Clearing a start bit freezes the count and the prescaler phase. Setting it again continues from where counting stopped.
- R8: Each channel has its own interrupt output, equal to its underflow flag ANDed with its interrupt enable (control bit 3).
- R9: Writing control bit 4 as 0 clears the flag, and writing it as 1 leaves the flag as it was.
- R10: Writes to reload and count load those registers directly. Any write to a control word restarts that channel's prescaler phase from zero.
- R11: Without the third channel, the bank at 0x20 to 0x28 is undecoded. Writing start bit 2 raises `err_pulse`, that bit is not kept, and interrupt output 2 stays low.
- R12: `rsp_valid` pulses, with `rsp_rdata`, in the cycle after a read request, and never after a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the window |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | DATA_W | Read data |
| err_pulse | output | 1 | One-cycle pulse after an undecoded or illegal access |
| octl_o | output | 1 | Output-control bit |
| irq_o | output | 3 | Per-channel interrupt, bit c for channel c |

## Verification
A wrong count or a wrong prescaler phase inside a channel shows up at the bus as a wrong count value. The bench reads that value after pausing the channel, so the error is visible at the next read. A wrong decode shows as a missing or extra `err_pulse`, or as nonzero data one cycle after the access. The bench sweeps all 64 byte addresses in both configurations to expose it. A flag error reaches `irq_o` in the cycle after the prescaled step that should set it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned TMR_MAX_CH   = 3;
   localparam int unsigned OFF_OCTL     = 0;
   localparam int unsigned OFF_START    = 4;
   localparam int unsigned BANK_BASE    = 8;
   localparam int unsigned BANK_STRIDE  = 12;
   localparam int unsigned CTL_SEL_W    = 3;
   localparam int unsigned CTL_IE_BIT   = 3;
   localparam int unsigned CTL_FLAG_BIT = 4;

   typedef enum logic [1:0] {
      REG_RELOAD = 2'd0,
      REG_COUNT  = 2'd1,
      REG_CTRL   = 2'd2,
      REG_NONE   = 2'd3
   } tmr_reg_e;

   typedef struct packed {
      logic                  hit_octl;
      logic                  hit_start;
      logic [TMR_MAX_CH-1:0] hit_ch;
      tmr_reg_e              reg_sel;
      logic                  miss;
   } tmr_dec_t;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned NCH      = 3,
   parameter bit          HAS_OCTL = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output tmr_dec_t          dec
);
   logic aligned;
   logic [TMR_MAX_CH-1:0] bank_hit;
   logic [1:0] bank_idx [TMR_MAX_CH];

   assign aligned = (addr[1:0] == 2'b00);

   for (genvar c = 0; c < TMR_MAX_CH; c++) begin : g_bank
      if (c < NCH) begin : g_on
         localparam int unsigned BASE = BANK_BASE + c * BANK_STRIDE;
         logic [ADDR_W-1:0] rel;
         assign rel         = addr - ADDR_W'(BASE);
         assign bank_hit[c] = aligned && (addr >= ADDR_W'(BASE)) &&
                              (rel < ADDR_W'(BANK_STRIDE));
         assign bank_idx[c] = rel[3:2];
      end else begin : g_off
         assign bank_hit[c] = 1'b0;
         assign bank_idx[c] = 2'd3;
      end
   end

   always_comb begin
      dec.hit_octl  = HAS_OCTL && aligned && (addr == ADDR_W'(OFF_OCTL));
      dec.hit_start = aligned && (addr == ADDR_W'(OFF_START));
      dec.hit_ch    = bank_hit;
      dec.reg_sel   = REG_NONE;
      for (int c = 0; c < TMR_MAX_CH; c++) begin
         if (bank_hit[c]) dec.reg_sel = tmr_reg_e'(bank_idx[c]);
      end
      dec.miss = !(dec.hit_octl || dec.hit_start || (|bank_hit));
   end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int unsigned SEL_W   = 3,
   parameter int unsigned MAX_SEL = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int unsigned PS_W = 2 * (MAX_SEL + 1);

   logic [PS_W-1:0] ps_q;
   logic [PS_W-1:0] mask;

   function automatic logic [PS_W-1:0] sel_mask(input logic [SEL_W-1:0] s);
      logic [PS_W-1:0] m;
      m = '0;
      for (int k = 0; k <= int'(MAX_SEL); k++) begin
         if (k <= int'(s)) m[2*k +: 2] = 2'b11;
      end
      return m;
   endfunction

   assign mask = sel_mask(sel);
   assign tick = run && ((ps_q & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n)   ps_q <= '0;
      else if (clr) ps_q <= '0;
      else if (run) ps_q <= ps_q + 1'b1;
   end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned MAX_SEL = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              wr_reload,
   input  logic              wr_count,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] reload_o,
   output logic [DATA_W-1:0] count_o,
   output logic [DATA_W-1:0] ctrl_o,
   output logic              irq_o
);
   logic [DATA_W-1:0]    reload_q, count_q;
   logic [CTL_SEL_W-1:0] sel_q;
   logic                 ie_q, flag_q;
   logic                 tick, underflow;

   tmr_prescale #(.SEL_W(CTL_SEL_W), .MAX_SEL(MAX_SEL)) u_ps (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .clr  (wr_ctrl),
      .sel  (sel_q),
      .tick (tick)
   );

   assign underflow = tick && (count_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '1;
         count_q  <= '1;
         sel_q    <= '0;
         ie_q     <= 1'b0;
         flag_q   <= 1'b0;
      end else begin
         if (wr_reload) reload_q <= wdata;
         if (wr_count)       count_q <= wdata;
         else if (underflow) count_q <= reload_q;
         else if (tick)      count_q <= count_q - 1'b1;
         if (wr_ctrl) begin
            sel_q <= wdata[CTL_SEL_W-1:0];
            ie_q  <= wdata[CTL_IE_BIT];
         end
         if (underflow)                          flag_q <= 1'b1;
         else if (wr_ctrl && !wdata[CTL_FLAG_BIT]) flag_q <= 1'b0;
      end
   end

   assign reload_o = reload_q;
   assign count_o  = count_q;
   assign ctrl_o   = DATA_W'({flag_q, ie_q, sel_q});
   assign irq_o    = flag_q && ie_q;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned DATA_W   = 32,
   parameter bit          THREE_CH = 1'b1,
   parameter bit          HAS_OCTL = 1'b1,
   parameter int unsigned MAX_SEL  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic                  rsp_valid,
   output logic [DATA_W-1:0]     rsp_rdata,
   output logic                  err_pulse,
   output logic                  octl_o,
   output logic [TMR_MAX_CH-1:0] irq_o
);
   localparam int unsigned NCH = THREE_CH ? 3 : 2;
   localparam logic [TMR_MAX_CH-1:0] CH_MASK = TMR_MAX_CH'((1 << NCH) - 1);

   if (ADDR_W < 6)   begin : g_bad_addr  $error("ADDR_W must cover the window"); end
   if (DATA_W < 8)   begin : g_bad_data  $error("DATA_W too small"); end
   if (MAX_SEL > 7)  begin : g_bad_sel   $error("MAX_SEL exceeds select field"); end

   tmr_dec_t dec;
   logic wr, rd, start_bad;
   logic octl_q;
   logic [TMR_MAX_CH-1:0] start_q;
   logic [TMR_MAX_CH-1:0][DATA_W-1:0] rel_vec, cnt_vec, ctl_vec;
   logic [DATA_W-1:0] rd_next, rdata_q;
   logic rvalid_q, err_q;

   tmr_decode #(.ADDR_W(ADDR_W), .NCH(NCH), .HAS_OCTL(HAS_OCTL)) u_dec (
      .addr(req_addr),
      .dec (dec)
   );

   assign wr        = req_valid && req_write;
   assign rd        = req_valid && !req_write;
   assign start_bad = wr && dec.hit_start && (NCH < TMR_MAX_CH) &&
                      req_wdata[TMR_MAX_CH-1];

   for (genvar c = 0; c < TMR_MAX_CH; c++) begin : g_ch
      if (c < NCH) begin : g_on
         logic sel_me;
         assign sel_me = wr && dec.hit_ch[c];
         tmr_channel #(.DATA_W(DATA_W), .MAX_SEL(MAX_SEL)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (start_q[c]),
            .wr_reload(sel_me && (dec.reg_sel == REG_RELOAD)),
            .wr_count (sel_me && (dec.reg_sel == REG_COUNT)),
            .wr_ctrl  (sel_me && (dec.reg_sel == REG_CTRL)),
            .wdata    (req_wdata),
            .reload_o (rel_vec[c]),
            .count_o  (cnt_vec[c]),
            .ctrl_o   (ctl_vec[c]),
            .irq_o    (irq_o[c])
         );
      end else begin : g_off
         assign rel_vec[c] = '0;
         assign cnt_vec[c] = '0;
         assign ctl_vec[c] = '0;
         assign irq_o[c]   = 1'b0;
      end
   end

   always_comb begin
      rd_next = '0;
      if (dec.hit_octl)       rd_next = DATA_W'(octl_q);
      else if (dec.hit_start) rd_next = DATA_W'(start_q);
      else begin
         for (int c = 0; c < TMR_MAX_CH; c++) begin
            if (dec.hit_ch[c]) begin
               case (dec.reg_sel)
                  REG_RELOAD: rd_next = rel_vec[c];
                  REG_COUNT:  rd_next = cnt_vec[c];
                  REG_CTRL:   rd_next = ctl_vec[c];
                  default:    rd_next = '0;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         octl_q   <= 1'b0;
         start_q  <= '0;
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         rvalid_q <= rd;
         rdata_q  <= rd ? rd_next : '0;
         err_q    <= req_valid && (dec.miss || start_bad);
         if (wr && dec.hit_octl)  octl_q  <= req_wdata[0];
         if (wr && dec.hit_start) start_q <= req_wdata[TMR_MAX_CH-1:0] & CH_MASK;
      end
   end

   assign rsp_valid = rvalid_q;
   assign rsp_rdata = rdata_q;
   assign err_pulse = err_q;
   assign octl_o    = octl_q;
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
   parameter int unsigned DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_write,
   input logic          rsp_valid,
   input logic          err_pulse,
   input logic          octl_o,
   input logic [2:0]    irq_o,
   input logic [2:0]    run,
   input logic [DW-1:0] cnt0
);
   assert_err_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> $past(req_valid));

   assert_rsp_after_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && !req_write));

   assert_octl_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(octl_o) |-> $past(req_valid && req_write));

   assert_run_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(run) |-> $past(req_valid && req_write));

   assert_frozen_when_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(run[0]) && !$past(req_valid && req_write)) |-> $stable(cnt0));

   assert_irq_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[0]) |-> $past(run[0] || (req_valid && req_write)));
endmodule

bind tmr_unit tmr_unit_chk #(.DW(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_write(req_write),
   .rsp_valid(rsp_valid),
   .err_pulse(err_pulse),
   .octl_o   (octl_o),
   .irq_o    (irq_o),
   .run      (start_q),
   .cnt0     (cnt_vec[0])
);

// File: tb/tmr_unit_test.sv
module tmr_unit_test;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic        req_valid, req_write;
   logic [5:0]  req_addr;
   logic [31:0] req_wdata;
   logic        rsp_valid, err_pulse, octl_o;
   logic [31:0] rsp_rdata;
   logic [2:0]  irq_o;
   logic        rv2, err2, oc2;
   logic [31:0] rd2;
   logic [2:0]  irq2;

   tmr_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .err_pulse(err_pulse), .octl_o(octl_o), .irq_o(irq_o)
   );

   tmr_unit #(.THREE_CH(1'b0)) uut2 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv2),
      .rsp_rdata(rd2), .err_pulse(err2), .octl_o(oc2), .irq_o(irq2)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] c_rd, c_rd2;
   logic        c_rv, c_err, c_err2;

   // reference model of the one channel currently running
   logic [31:0] m_cnt, m_rel;
   logic        m_flag, m_ie;
   int          m_sel, m_acc;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic bus(input logic w, input logic [5:0] a, input logic [31:0] d);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      c_rd = rsp_rdata; c_rv = rsp_valid; c_err = err_pulse;
      c_rd2 = rd2; c_err2 = err2;
   endtask

   function automatic int div_of(input int sel);
      int e;
      e = (sel > 4) ? 4 : sel;
      return 1 << (2 * (e + 1));
   endfunction

   function automatic logic [5:0] base_of(input int ch);
      return 6'(8 + 12 * ch);
   endfunction

   task automatic cfg(input int ch, input logic [31:0] rel, input logic [31:0] cnt,
                      input int sel, input logic ie);
      bus(1'b1, base_of(ch), rel);
      bus(1'b1, base_of(ch) + 6'd4, cnt);
      bus(1'b1, base_of(ch) + 6'd8, 32'(sel) | (32'(ie) << 3));
      m_rel = rel; m_cnt = cnt; m_sel = sel; m_ie = ie; m_flag = 1'b0; m_acc = 0;
   endtask

   task automatic run_ch(input int ch, input int k);
      int d, t;
      bus(1'b1, 6'h04, 32'(1) << ch);
      repeat (k) @(negedge clk);
      bus(1'b1, 6'h04, 32'h0);
      d = div_of(m_sel);
      t = (m_acc + k + 1) / d - m_acc / d;
      m_acc = m_acc + k + 1;
      for (int i = 0; i < t; i++) begin
         if (m_cnt == 0) begin m_cnt = m_rel; m_flag = 1'b1; end
         else m_cnt = m_cnt - 1;
      end
   endtask

   task automatic check_ch(input int ch, input string tag);
      bus(1'b0, base_of(ch) + 6'd4, 32'h0);
      chk({tag, " count"}, c_rd, m_cnt);
      bus(1'b0, base_of(ch) + 6'd8, 32'h0);
      chk("R6 flag/ctrl", c_rd, {27'd0, m_flag, m_ie, 3'(m_sel)});
      chk("R8 irq", 32'(irq_o[ch]), 32'(m_flag & m_ie));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int sels[2] = '{0, 1};
      int rels[4] = '{0, 1, 3, 7};
      int ks[4]   = '{2, 5, 9, 17};
      bit dec1, dec2;
      logic [31:0] keep_rel;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", 32'(irq_o), 0);
      chk("R1 octl_o", 32'(octl_o), 0);
      chk("R1 err", 32'(err_pulse), 0);
      bus(1'b0, 6'h00, 0); chk("R1 octl reg", c_rd, 0);
      bus(1'b0, 6'h04, 0); chk("R1 start", c_rd, 0);
      for (int ch = 0; ch < 3; ch++) begin
         bus(1'b0, base_of(ch), 0);         chk("R1 reload", c_rd, 32'hFFFF_FFFF);
         bus(1'b0, base_of(ch) + 6'd4, 0);  chk("R1 count", c_rd, 32'hFFFF_FFFF);
         bus(1'b0, base_of(ch) + 6'd8, 0);  chk("R1 ctrl", c_rd, 0);
      end

      // R3 output control
      bus(1'b1, 6'h00, 32'hFFFF_FFFF);
      chk("R3 octl_o set", 32'(octl_o), 1);
      bus(1'b0, 6'h00, 0); chk("R3 readback", c_rd, 1);
      bus(1'b1, 6'h00, 32'h0000_0002);
      chk("R3 octl_o bit0 only", 32'(octl_o), 0);

      // R4 start register readback
      bus(1'b1, 6'h04, 32'h5);
      bus(1'b0, 6'h04, 0); chk("R4 start readback", c_rd, 5);
      bus(1'b1, 6'h04, 32'hFFFF_FFF8);
      bus(1'b0, 6'h04, 0); chk("R4 upper bits read 0", c_rd, 0);

      // R12 response strobe
      bus(1'b0, 6'h04, 0); chk("R12 rsp after read", 32'(c_rv), 1);
      bus(1'b1, 6'h00, 0); chk("R12 no rsp after write", 32'(c_rv), 0);

      // R5/R6 sweep over prescale, reload and run length on channel 0
      for (int s = 0; s < 2; s++) begin
         for (int r = 0; r < 4; r++) begin
            cfg(0, 32'(rels[r]), 32'd2, sels[s], 1'(r));
            bus(1'b0, base_of(0), 0); chk("R10 reload written", c_rd, 32'(rels[r]));
            for (int k = 0; k < 4; k++) begin
               run_ch(0, ks[k]);
               check_ch(0, "R5/R6");
            end
         end
      end

      // R7 stop freezes, resume continues prescale phase
      cfg(0, 32'd10, 32'd100, 0, 1'b0);
      run_ch(0, 6);
      bus(1'b0, 6'h0C, 0); chk("R7 after 7 cycles", c_rd, m_cnt);
      repeat (30) @(negedge clk);
      bus(1'b0, 6'h0C, 0); chk("R7 frozen while stopped", c_rd, m_cnt);
      run_ch(0, 0);
      bus(1'b0, 6'h0C, 0); chk("R7 resume keeps phase", c_rd, m_cnt);
      chk("R7 model sanity", m_cnt, 98);

      // R10 control write restarts the prescaler
      cfg(0, 32'd10, 32'd50, 0, 1'b0);
      run_ch(0, 2);
      bus(1'b1, 6'h10, 32'h0); m_acc = 0;
      run_ch(0, 2);
      bus(1'b0, 6'h0C, 0); chk("R10 prescaler restart", c_rd, 32'd50);

      // R5 select above 4 acts as 4
      cfg(0, 32'd0, 32'd5, 7, 1'b0);
      run_ch(0, 1022);
      bus(1'b0, 6'h0C, 0); chk("R5 clamp no step yet", c_rd, 32'd5);
      run_ch(0, 0);
      bus(1'b0, 6'h0C, 0); chk("R5 clamp step at 1024", c_rd, 32'd4);

      // R8/R9 per-channel interrupt and flag clearing
      bus(1'b1, 6'h10, 32'h0);
      cfg(1, 32'd2, 32'd0, 0, 1'b1);
      run_ch(1, 3);
      chk("R8 irq ch1 raised", 32'(irq_o[1]), 1);
      chk("R8 irq ch0 quiet", 32'(irq_o[0]), 0);
      check_ch(1, "R6");
      bus(1'b1, 6'h1C, 32'h18);
      chk("R9 write 1 keeps flag", 32'(irq_o[1]), 1);
      bus(1'b1, 6'h1C, 32'h08);
      chk("R9 write 0 clears flag", 32'(irq_o[1]), 0);
      cfg(0, 32'd4, 32'd0, 0, 1'b0);
      run_ch(0, 3);
      chk("R8 flag without enable", 32'(irq_o[0]), 0);
      check_ch(0, "R6");
      keep_rel = m_rel;

      // R2 and R11: sweep every byte address in both configurations
      for (int a = 0; a < 64; a++) begin
         dec1 = (a % 4 == 0) && (a == 0 || a == 4 || (a >= 8 && a < 44));
         dec2 = (a % 4 == 0) && (a == 0 || a == 4 || (a >= 8 && a < 32));
         bus(1'b0, 6'(a), 0);
         chk($sformatf("R2 err at 0x%02h", a), 32'(c_err), 32'(!dec1));
         chk($sformatf("R11 err at 0x%02h", a), 32'(c_err2), 32'(!dec2));
         if (!dec1) chk("R2 undecoded reads 0", c_rd, 0);
         if (!dec2) chk("R11 absent bank reads 0", c_rd2, 0);
      end

      // R2 writes to undecoded or misaligned addresses change nothing
      bus(1'b1, 6'h09, 32'hFFFF_FFFF); chk("R2 misaligned write err", 32'(c_err), 1);
      bus(1'b1, 6'h02, 32'hFFFF_FFFF); chk("R2 misaligned write err", 32'(c_err), 1);
      bus(1'b1, 6'h05, 32'hFFFF_FFFF); chk("R2 misaligned write err", 32'(c_err), 1);
      bus(1'b1, 6'h2C, 32'hFFFF_FFFF); chk("R2 gap write err", 32'(c_err), 1);
      bus(1'b1, 6'h3C, 32'hFFFF_FFFF); chk("R2 gap write err", 32'(c_err), 1);
      bus(1'b0, 6'h08, 0); chk("R2 reload untouched", c_rd, keep_rel);
      bus(1'b0, 6'h00, 0); chk("R2 octl untouched", c_rd, 0);
      bus(1'b0, 6'h04, 0); chk("R2 start untouched", c_rd, 0);
      chk("R2 err clears", 32'(err_pulse), 0);

      // R11 two-channel instance: start bit 2 is illegal and dropped
      bus(1'b1, 6'h04, 32'h7);
      chk("R11 start bit2 err", 32'(c_err2), 1);
      chk("R4 start 7 legal with 3 ch", 32'(c_err), 0);
      bus(1'b0, 6'h04, 0);
      chk("R11 start bit2 dropped", c_rd2, 3);
      chk("R4 start readback 3 ch", c_rd, 7);
      bus(1'b1, 6'h04, 32'h0);
      chk("R11 irq2 low", 32'(irq2[2]), 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule